// File: doc/BRIEF.md
# Split-Transaction Bus Requester Interface

This block is the bus-facing side of one device on a synchronous bus where each cycle carries one whole packet and arbitration for the next cycle overlaps the current transfer. The local side issues a one-cycle send command with a destination address, a source address and a data word. The interface latches the packet and raises a request. The request passes through a two-flop synchroniser before it leaves the block. The interface then waits for the arbiter's grant. Once the grant is taken, the packet is driven onto the bus for exactly one bus cycle.

At the end of that cycle the interface samples the receivers' accept line. It reports the outcome to the local side with a one-cycle done pulse. If no receiver accepted, it also sets a sticky error flag that only an explicit clear removes. A memory read on this bus is two independent transactions: the outgoing request packet, and a later return packet that the memory sends through its own copy of this interface. Each send command therefore stands alone and expects no reply here.

Top module: `splitbus_requester`

## Requirements
- R1: After reset, busy, bus_req, bus_drive, done, done_ok and err_flag are 0, and bus_pkt is all zeros.
- R2: A send_valid sampled while busy is 0 captures the packet fields, and busy is 1 from the next cycle on.
- R3: bus_req first reads 1 exactly two cycles after busy first reads 1 (SYNC_STAGES=2 register stages). Before that, bus_req is 0.
- R4: bus_req is 0 in every cycle in which bus_ack is 1. Once a grant is taken, bus_req stays 0 until a new send command is accepted.
- R5: bus_ack has no effect unless the synchronised request is already at its last stage. An ack while idle, or before bus_req has risen, leaves bus_drive at 0 and busy unchanged.
- R6: In the cycle after bus_ack is sampled with bus_req pending, bus_drive is 1 for exactly one cycle. In that cycle bus_pkt carries the destination in bits [63:32], the source in bits [31:16] and the data in bits [15:0].
- R7: bus_pkt is all zeros in every cycle in which bus_drive is 0.
- R8: In the cycle after the transfer cycle, done is 1 for one cycle, done_ok equals bus_accept as sampled at the end of the transfer cycle, and busy is 0.
- R9: If bus_accept is 0 at the end of a transfer cycle, err_flag becomes 1. It stays 1 through later accepted transfers until it is cleared.
- R10: err_clr clears err_flag at the next edge. If a failed accept is sampled at the same edge, the flag is set and not cleared.
- R11: A send_valid while busy is 1 is ignored, so the transfer in progress carries the packet captured first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_valid | input | 1 | One-cycle send command from the local side |
| send_dst | input | 32 | Destination address of the packet |
| send_src | input | 16 | Source address of the packet |
| send_data | input | 16 | Data word of the packet |
| err_clr | input | 1 | Clears the sticky no-receiver error |
| busy | output | 1 | A packet is pending or in transfer |
| done | output | 1 | One-cycle pulse when the accept sample is taken |
| done_ok | output | 1 | Accept status that goes with done |
| err_flag | output | 1 | Sticky flag: a packet was not accepted |
| bus_req | output | 1 | Synchronised request to the arbiter |
| bus_ack | input | 1 | Grant from the arbiter |
| bus_drive | output | 1 | High in the owned transfer cycle |
| bus_pkt | output | 64 | Packet on the bus, zero outside the transfer cycle |
| bus_accept | input | 1 | A receiver claimed the packet |

## Verification
Two events can fall on the same clock edge: a failed accept sample, and the local side's clear of the error flag. The bench raises err_clr in the transfer cycle of every second packet, with the accept line both high and low. A cleared flag is expected after an accepted packet, and a set flag after a refused one. A second overlap comes from send commands that arrive while a packet is still in flight. The bench issues them while busy and judges them by the packet that then appears on the bus.

// File: rtl/splitbus_pkg.sv
package splitbus_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PEND = 2'd1,
    SQ_XFER = 2'd2
  } seq_state_t;
endpackage

// File: rtl/splitbus_sync.sv
module splitbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic flush,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb chain_d[i] = flush ? 1'b0 : d;
      end else begin : g_rest
        always_comb chain_d[i] = flush ? 1'b0 : chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/splitbus_seq.sv
module splitbus_seq
  import splitbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic send_valid,
  input  logic ack,
  input  logic req_last,
  output logic load,
  output logic take,
  output logic raw_req,
  output logic xfer,
  output logic busy
);
  seq_state_t state_q, state_d;

  always_comb begin
    load    = (state_q == SQ_IDLE) && send_valid;
    take    = (state_q == SQ_PEND) && ack && req_last;
    state_d = state_q;
    case (state_q)
      SQ_IDLE: if (load) state_d = SQ_PEND;
      SQ_PEND: if (take) state_d = SQ_XFER;
      SQ_XFER: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign raw_req = (state_q == SQ_PEND);
  assign xfer    = (state_q == SQ_XFER);
  assign busy    = (state_q != SQ_IDLE);
endmodule

// File: rtl/splitbus_pktdrv.sv
module splitbus_pktdrv #(
  parameter int DST_W  = 32,
  parameter int SRC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          take,
  input  logic [DST_W-1:0]              dst,
  input  logic [SRC_W-1:0]              src,
  input  logic [DATA_W-1:0]             data,
  output logic [DST_W+SRC_W+DATA_W-1:0] pkt
);
  localparam int PKT_W = DST_W + SRC_W + DATA_W;

  logic [PKT_W-1:0] hold_q, hold_d;
  logic [PKT_W-1:0] out_q, out_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = {dst, src, data};
    out_d = take ? hold_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign pkt = out_q;
endmodule

// File: rtl/splitbus_status.sv
module splitbus_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic accept,
  input  logic clr,
  output logic done,
  output logic done_ok,
  output logic err
);
  logic done_q, done_d;
  logic ok_q, ok_d;
  logic err_q, err_d;

  always_comb begin
    done_d = sample;
    ok_d   = sample ? accept : ok_q;
    err_d  = err_q;
    if (clr)              err_d = 1'b0;
    if (sample && !accept) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
    end
  end

  assign done    = done_q;
  assign done_ok = ok_q & done_q;
  assign err     = err_q;
endmodule

// File: rtl/splitbus_requester.sv
module splitbus_requester #(
  parameter int DST_W       = 32,
  parameter int SRC_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          send_valid,
  input  logic [DST_W-1:0]              send_dst,
  input  logic [SRC_W-1:0]              send_src,
  input  logic [DATA_W-1:0]             send_data,
  input  logic                          err_clr,
  output logic                          busy,
  output logic                          done,
  output logic                          done_ok,
  output logic                          err_flag,
  output logic                          bus_req,
  input  logic                          bus_ack,
  output logic                          bus_drive,
  output logic [DST_W+SRC_W+DATA_W-1:0] bus_pkt,
  input  logic                          bus_accept
);
  logic load, take, raw_req, xfer, req_last;

  splitbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .send_valid(send_valid), .ack(bus_ack),
    .req_last(req_last), .load(load), .take(take), .raw_req(raw_req),
    .xfer(xfer), .busy(busy)
  );

  splitbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_req), .flush(take), .q(req_last)
  );

  splitbus_pktdrv #(.DST_W(DST_W), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_pkt (
    .clk(clk), .rst_n(rst_n), .load(load), .take(take),
    .dst(send_dst), .src(send_src), .data(send_data), .pkt(bus_pkt)
  );

  splitbus_status u_stat (
    .clk(clk), .rst_n(rst_n), .sample(xfer), .accept(bus_accept),
    .clr(err_clr), .done(done), .done_ok(done_ok), .err(err_flag)
  );

  assign bus_req   = req_last & ~bus_ack;
  assign bus_drive = xfer;
endmodule

// File: rtl/splitbus_requester_chk.sv
module splitbus_requester_chk #(
  parameter int PKT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_clr,
  input logic             busy,
  input logic             done,
  input logic             done_ok,
  input logic             err_flag,
  input logic             bus_req,
  input logic             bus_ack,
  input logic             bus_drive,
  input logic [PKT_W-1:0] bus_pkt,
  input logic             bus_accept
);
  assert_req_low_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> !bus_req);
  assert_req_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);
  assert_drive_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |=> !bus_drive);
  assert_drive_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> busy);
  assert_pkt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_pkt == '0));
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |=> (done && !busy));
  assert_done_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |=> (done_ok == $past(bus_accept)));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && !bus_accept) |=> err_flag);
endmodule

bind splitbus_requester splitbus_requester_chk #(.PKT_W(DST_W+SRC_W+DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .busy(busy), .done(done),
  .done_ok(done_ok), .err_flag(err_flag), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_drive(bus_drive), .bus_pkt(bus_pkt), .bus_accept(bus_accept)
);

// File: tb/splitbus_requester_test.sv
module splitbus_requester_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        send_valid = 1'b0;
  logic [31:0] send_dst = '0;
  logic [15:0] send_src = '0;
  logic [15:0] send_data = '0;
  logic        err_clr = 1'b0;
  logic        bus_ack = 1'b0;
  logic        bus_accept = 1'b0;
  logic        busy, done, done_ok, err_flag, bus_req, bus_drive;
  logic [63:0] bus_pkt;

  int checks = 0;
  int fails = 0;
  logic err_exp = 1'b0;

  always #5 clk = ~clk;

  splitbus_requester uut (
    .clk(clk), .rst_n(rst_n), .send_valid(send_valid), .send_dst(send_dst),
    .send_src(send_src), .send_data(send_data), .err_clr(err_clr),
    .busy(busy), .done(done), .done_ok(done_ok), .err_flag(err_flag),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_drive(bus_drive),
    .bus_pkt(bus_pkt), .bus_accept(bus_accept)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int idx, input int ack_wait, input bit acc,
                      input bit clr, input bit spur);
    logic [31:0] dst;
    logic [15:0] src, dat;
    logic [63:0] exp_pkt;
    dst = 32'h1000_0000 + 32'(idx) * 32'h0101;
    src = 16'hA000 ^ 16'(idx);
    dat = 16'(idx) * 16'h1111 + 16'd7;
    exp_pkt = {dst, src, dat};
    send_valid = 1'b1; send_dst = dst; send_src = src; send_data = dat;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after send", 64'(busy), 64'd1);
    chk(bus_req == 1'b0, "R3 req low stage0", 64'(bus_req), 64'd0);
    // R11: a second command while busy, with different fields
    send_dst = ~dst; send_src = ~src; send_data = ~dat;
    bus_ack = spur;
    @(negedge clk);
    send_valid = 1'b0;
    bus_ack = 1'b0;
    chk(bus_drive == 1'b0, "R5 early ack ignored", 64'(bus_drive), 64'd0);
    chk(bus_req == 1'b0, "R3 req low stage1", 64'(bus_req), 64'd0);
    @(negedge clk);
    chk(bus_req == 1'b1, "R3 req high after two stages", 64'(bus_req), 64'd1);
    for (int w = 0; w < ack_wait; w++) begin
      @(negedge clk);
      chk(bus_req == 1'b1 && bus_drive == 1'b0, "R3 req held waiting",
          64'({bus_req, bus_drive}), 64'b10);
    end
    bus_ack = 1'b1;
    #1;
    chk(bus_req == 1'b0, "R4 req dropped under ack", 64'(bus_req), 64'd0);
    @(negedge clk);
    bus_ack = 1'b0;
    chk(bus_drive == 1'b1, "R6 drive in transfer cycle", 64'(bus_drive), 64'd1);
    chk(bus_pkt == exp_pkt, "R6 R11 packet layout", bus_pkt, exp_pkt);
    chk(bus_req == 1'b0, "R4 req stays low after grant", 64'(bus_req), 64'd0);
    bus_accept = acc;
    err_clr = clr;
    if (!acc) err_exp = 1'b1;
    else if (clr) err_exp = 1'b0;
    @(negedge clk);
    bus_accept = 1'b0;
    err_clr = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R8 done and not busy",
        64'({done, busy}), 64'b10);
    chk(done_ok == acc, "R8 done_ok equals accept", 64'(done_ok), 64'(acc));
    chk(bus_drive == 1'b0 && bus_pkt == '0, "R7 bus quiet after transfer",
        bus_pkt, 64'd0);
    chk(err_flag == err_exp, "R9 R10 error flag", 64'(err_flag), 64'(err_exp));
    chk(bus_req == 1'b0, "R4 req low at done", 64'(bus_req), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done is one pulse", 64'(done), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(busy == 0 && bus_req == 0 && bus_drive == 0 && done == 0 &&
        done_ok == 0 && err_flag == 0, "R1 reset outputs",
        64'({busy, bus_req, bus_drive, done, done_ok, err_flag}), 64'd0);
    chk(bus_pkt == '0, "R1 reset packet", bus_pkt, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: ack while idle does nothing
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    chk(bus_drive == 1'b0 && busy == 1'b0, "R5 idle ack ignored",
        64'({bus_drive, busy}), 64'd0);
    @(negedge clk);
    chk(bus_drive == 1'b0 && bus_pkt == '0, "R7 idle bus quiet", bus_pkt, 64'd0);
    for (int aw = 0; aw < 4; aw++)
      for (int a = 0; a < 2; a++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 2; s++)
            xfer(aw * 8 + a * 4 + c * 2 + s + 1, aw, bit'(a), bit'(c), bit'(s));
    // R10: explicit clear while idle
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_flag == 1'b0, "R10 idle clear", 64'(err_flag), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule